// File: doc/BRIEF.md
# Frequency Window Classifier by Period Race

This block decides whether a test frequency sits below, inside or above a window bounded by two reference frequencies. It does this without counting. Three unrelated input signals race each other: a low reference, a high reference and the test signal. Whichever finishes one full period first sets the order. Each input passes through its own synchronizer into a period detector. A period detector reports completion once it has seen two edges of the chosen polarity.

A small order register, clocked by the system clock, holds which detectors had already finished at the previous clock. The verdict comes from the transition in which the test detector finishes, judged against that registered history:

- If the test signal beats the high reference, the block pulses FAST.
- If it finishes after the high reference but before the low reference, the block pulses OK.
- If it finishes after both references, the block pulses SLOW.

Every verdict clears all detectors and the order register, and a new race starts at once. An enable input holds the whole block cleared while it is low. Timeout and error handling belong to a separate block.

Top module: `freq_window_cls`

## Requirements
- R1: While `rst_ni` is low, `fast_o`, `ok_o` and `slow_o` are 0, and no detector progress survives reset.
- R2: Each input passes through SYNC_STAGES flops. A detector completes after two edges of the chosen polarity (rising by default, EDGE_RISE=1). The verdict output rises on the (SYNC_STAGES+1)-th rising clock edge after the clock edge that first samples the completing input edge.
- R3: `fast_o` pulses when the test detector completes while the high reference was not registered complete in the previous clock.
- R4: `ok_o` pulses when the test detector completes while the high reference was registered complete and the low reference was not.
- R5: `slow_o` pulses when the test detector completes while both references were registered complete.
- R6: A completion in the same clock as the test completion does not count as earlier. Ties therefore resolve toward the faster verdict: test tied with high gives FAST, and test tied with low (high already done) gives OK.
- R7: At most one of the three outputs is high in any cycle, and each pulse lasts exactly one clock.
- R8: The clock that registers a verdict also clears all detectors and the order register. Input edges counted in that clock are discarded, and the next verdict needs two fresh test edges.
- R9: While `en_i` is low, the detectors are held cleared and no output pulses; `en_i` is sampled on the system clock.
- R10: Reference completions on their own never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Arms the detectors when high; synchronous to clk_i |
| ref_lo_i | input | 1 | Low reference frequency, asynchronous |
| ref_hi_i | input | 1 | High reference frequency, asynchronous |
| test_i | input | 1 | Frequency under test, asynchronous |
| fast_o | output | 1 | One-cycle pulse: test above the window |
| ok_o | output | 1 | One-cycle pulse: test inside the window |
| slow_o | output | 1 | One-cycle pulse: test below the window |

## Verification
Free-running waveforms are chosen so that the period race has only one possible winner: a test period shorter than the high reference period, one between the two reference periods, and one longer than the low reference period. Each of these must yield only FAST, only OK or only SLOW respectively, which tells the three decode paths apart under realistic phase slip. Hand-placed single edges then pin down the latency, the two tie orders, reference-only completions and the need for fresh edges after a verdict. A run with enable low and active inputs shows that the block stays silent. A behavioural model checks every output on every clock throughout.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
   localparam int NUM_CH  = 3;
   localparam int CH_HI   = 0;
   localparam int CH_LO   = 1;
   localparam int CH_TST  = 2;
   localparam int EDGES_PER_PERIOD = 2;

   typedef struct packed {
      logic slow;
      logic ok;
      logic fast;
   } verdict_t;
endpackage

// File: rtl/fwc_sync.sv
module fwc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("fwc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fwc_period_det.sv
module fwc_period_det #(
   parameter bit RISE   = 1'b1,
   parameter int NEEDED = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic sig_i,
   output logic done_o
);
   localparam int CW = $clog2(NEEDED + 1);

   if (NEEDED < 1) begin : g_bad_needed
      $error("fwc_period_det: NEEDED must be positive");
   end

   logic          prev_q;
   logic          edge_seen;
   logic [CW-1:0] cnt_q;

   if (RISE) begin : g_rise
      assign edge_seen = sig_i & ~prev_q;
   end else begin : g_fall
      assign edge_seen = ~sig_i & prev_q;
   end

   assign done_o = (cnt_q == CW'(NEEDED));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= sig_i;
         if (clr_i)                    cnt_q <= '0;
         else if (edge_seen && !done_o) cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/fwc_order_dec.sv
module fwc_order_dec
   import fwc_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic [NUM_CH-1:0] nxt_i,
   output logic [NUM_CH-1:0] cur_o,
   output logic              clr_o,
   output verdict_t          vd_o
);
   logic [NUM_CH-1:0] cur_q;
   logic              tst_new;
   verdict_t          dec;

   always_comb begin
      tst_new  = nxt_i[CH_TST] & ~cur_q[CH_TST] & en_i;
      dec.fast = tst_new & ~cur_q[CH_HI];
      dec.ok   = tst_new &  cur_q[CH_HI] & ~cur_q[CH_LO];
      dec.slow = tst_new &  cur_q[CH_HI] &  cur_q[CH_LO];
   end

   assign clr_o = (|dec) | ~en_i;
   assign cur_o = cur_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q <= '0;
         vd_o  <= '0;
      end else begin
         cur_q <= clr_o ? '0 : nxt_i;
         vd_o  <= dec;
      end
   end
endmodule

// File: rtl/freq_window_cls.sv
module freq_window_cls
   import fwc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit EDGE_RISE   = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic ref_lo_i,
   input  logic ref_hi_i,
   input  logic test_i,
   output logic fast_o,
   output logic ok_o,
   output logic slow_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("freq_window_cls: SYNC_STAGES must be at least 2");
   end

   logic [NUM_CH-1:0] raw_in;
   logic [NUM_CH-1:0] synced;
   logic [NUM_CH-1:0] det_done;
   logic [NUM_CH-1:0] cur_state;
   logic              clr_all;
   verdict_t          verdict;

   assign raw_in[CH_HI]  = ref_hi_i;
   assign raw_in[CH_LO]  = ref_lo_i;
   assign raw_in[CH_TST] = test_i;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      fwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .d_i   (raw_in[g]),
         .q_o   (synced[g])
      );
      fwc_period_det #(.RISE(EDGE_RISE), .NEEDED(EDGES_PER_PERIOD)) u_det (
         .clk_i (clk_i),
         .rst_ni(rst_ni),
         .clr_i (clr_all),
         .sig_i (synced[g]),
         .done_o(det_done[g])
      );
   end

   fwc_order_dec u_dec (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .nxt_i (det_done),
      .cur_o (cur_state),
      .clr_o (clr_all),
      .vd_o  (verdict)
   );

   assign fast_o = verdict.fast;
   assign ok_o   = verdict.ok;
   assign slow_o = verdict.slow;
endmodule

// File: rtl/fwc_chk.sv
module fwc_chk (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       en_i,
   input logic       fast_o,
   input logic       ok_o,
   input logic       slow_o,
   input logic [2:0] cur_i,
   input logic [2:0] done_i
);
   // bit positions: 0 high reference, 1 low reference, 2 test
   p_single_verdict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({fast_o, ok_o, slow_o}));

   p_pulse_width_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_o | ok_o | slow_o) |=> !(fast_o | ok_o | slow_o));

   p_cleared_after_verdict_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fast_o | ok_o | slow_o) |-> (cur_i == 3'b000 && done_i == 3'b000));

   p_idle_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !(fast_o | ok_o | slow_o));

   p_fast_needs_no_hi_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fast_o |-> !$past(cur_i[0]));

   p_ok_needs_hi_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ok_o |-> ($past(cur_i[0]) && !$past(cur_i[1])));

   p_slow_needs_both_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slow_o |-> ($past(cur_i[0]) && $past(cur_i[1])));
endmodule

bind freq_window_cls fwc_chk u_chk (
   .clk_i (clk_i),
   .rst_ni(rst_ni),
   .en_i  (en_i),
   .fast_o(fast_o),
   .ok_o  (ok_o),
   .slow_o(slow_o),
   .cur_i (cur_state),
   .done_i(det_done)
);

// File: tb/freq_window_cls_tb.sv
`timescale 1ns/1ps
module freq_window_cls_tb;
   localparam int S = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic [2:0] ln = 3'b000;   // 0 high ref, 1 low ref, 2 test
   logic       fast_o, ok_o, slow_o;

   int total = 0;
   int bad = 0;
   int n_fast = 0, n_ok = 0, n_slow = 0;
   int r7_viol = 0;
   logic run = 1'b0;
   int half [3];

   always #2.5 clk = ~clk;

   freq_window_cls #(.SYNC_STAGES(S), .EDGE_RISE(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en),
      .ref_lo_i(ln[1]), .ref_hi_i(ln[0]), .test_i(ln[2]),
      .fast_o(fast_o), .ok_o(ok_o), .slow_o(slow_o));

   task automatic check(input bit cond, input string req, input int act, input int exp);
      total++;
      if (!cond) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: input history, period counts and completion order
   logic [7:0] hist [3];
   int  cnt [3];
   bit  cur [3];
   bit  m_fast, m_ok, m_slow;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 3; c++) begin hist[c] = '0; cnt[c] = 0; cur[c] = 0; end
         m_fast = 0; m_ok = 0; m_slow = 0;
      end else begin
         bit dn [3];
         bit tn, clr;
         for (int c = 0; c < 3; c++) dn[c] = (cnt[c] == 2);
         tn     = dn[2] && !cur[2] && en;
         m_fast = tn && !cur[0];
         m_ok   = tn && cur[0] && !cur[1];
         m_slow = tn && cur[0] && cur[1];
         clr    = m_fast || m_ok || m_slow || !en;
         for (int c = 0; c < 3; c++) begin
            bit ev;
            ev = hist[c][S-1] && !hist[c][S];
            if (clr) cnt[c] = 0;
            else if (ev && cnt[c] < 2) cnt[c] = cnt[c] + 1;
            cur[c]  = clr ? 1'b0 : dn[c];
            hist[c] = {hist[c][6:0], ln[c]};
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         check(fast_o == m_fast, "R3 model fast", fast_o, m_fast);
         check(ok_o   == m_ok,   "R4 model ok",   ok_o,   m_ok);
         check(slow_o == m_slow, "R5 model slow", slow_o, m_slow);
         if ((fast_o + ok_o + slow_o) > 1) r7_viol++;
         n_fast += fast_o; n_ok += ok_o; n_slow += slow_o;
      end
   end

   logic prev_any = 1'b0;
   always @(negedge clk) begin
      if (prev_any && (fast_o | ok_o | slow_o)) r7_viol++;
      prev_any = fast_o | ok_o | slow_o;
   end

   initial begin
      int c [3];
      for (int i = 0; i < 3; i++) c[i] = 0;
      forever begin
         @(negedge clk);
         if (run) begin
            for (int i = 0; i < 3; i++) begin
               c[i]++;
               if (c[i] >= half[i]) begin c[i] = 0; ln[i] = ~ln[i]; end
            end
         end else begin
            for (int i = 0; i < 3; i++) c[i] = 0;
         end
      end
   end

   task automatic pulse_in(input logic [2:0] m);
      @(negedge clk); ln = ln | m;
      repeat (3) @(negedge clk); ln = ln & ~m;
      repeat (3) @(negedge clk);
   endtask

   task automatic settle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic restart;
      run = 1'b0;
      @(negedge clk); ln = 3'b000; en = 1'b0;
      settle(6);
      en = 1'b1;
      settle(2);
   endtask

   task automatic free_run(input int h_hi, input int h_lo, input int h_t,
                           input int cycles, input int want, input string req);
      int f0, o0, s0, got, other;
      restart();
      half[0] = h_hi; half[1] = h_lo; half[2] = h_t;
      f0 = n_fast; o0 = n_ok; s0 = n_slow;
      run = 1'b1;
      settle(cycles);
      run = 1'b0;
      settle(S + 4);
      got   = (want == 0) ? n_fast - f0 : (want == 1) ? n_ok - o0 : n_slow - s0;
      other = (n_fast - f0) + (n_ok - o0) + (n_slow - s0) - got;
      check(got > 0, req, got, 1);
      check(other == 0, req, other, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int f0, o0, s0;
      half[0] = 10; half[1] = 60; half[2] = 4;
      settle(3);
      check({fast_o, ok_o, slow_o} == 3'b000, "R1 reset outputs", {fast_o, ok_o, slow_o}, 0);
      @(negedge clk); rst_n = 1'b1;
      settle(2);
      check({fast_o, ok_o, slow_o} == 3'b000, "R1 after reset", {fast_o, ok_o, slow_o}, 0);
      en = 1'b1;
      settle(4);

      // R2 latency and R3 via a lone test period
      pulse_in(3'b100);
      @(negedge clk); ln[2] = 1'b1;
      @(posedge clk);
      repeat (S) @(posedge clk);
      @(negedge clk);
      check(fast_o == 1'b0, "R2 early edge", fast_o, 0);
      @(posedge clk);
      @(negedge clk);
      check(fast_o == 1'b1, "R2 latency / R3 fast", fast_o, 1);
      @(negedge clk);
      check(fast_o == 1'b0, "R7 one cycle", fast_o, 0);
      ln[2] = 1'b0;
      settle(4);

      // R8: one fresh edge is not enough after a verdict
      f0 = n_fast;
      pulse_in(3'b100);
      settle(S + 4);
      check(n_fast == f0, "R8 single edge after clear", n_fast - f0, 0);
      pulse_in(3'b100);
      settle(S + 4);
      check(n_fast == f0 + 1, "R8 second fresh edge", n_fast - f0, 1);

      // R10 then R5
      f0 = n_fast; o0 = n_ok; s0 = n_slow;
      pulse_in(3'b001); pulse_in(3'b001);
      pulse_in(3'b010); pulse_in(3'b010);
      settle(10);
      check((n_fast + n_ok + n_slow) == (f0 + o0 + s0), "R10 refs only", n_fast + n_ok + n_slow - f0 - o0 - s0, 0);
      pulse_in(3'b100); pulse_in(3'b100);
      settle(S + 4);
      check(n_slow == s0 + 1, "R5 slow order", n_slow - s0, 1);

      // R4
      o0 = n_ok;
      pulse_in(3'b001); pulse_in(3'b001);
      pulse_in(3'b100); pulse_in(3'b100);
      settle(S + 4);
      check(n_ok == o0 + 1, "R4 ok order", n_ok - o0, 1);

      // R6 ties
      f0 = n_fast;
      pulse_in(3'b101); pulse_in(3'b101);
      settle(S + 4);
      check(n_fast == f0 + 1, "R6 tie test/high gives fast", n_fast - f0, 1);
      o0 = n_ok;
      pulse_in(3'b001); pulse_in(3'b001);
      pulse_in(3'b110); pulse_in(3'b110);
      settle(S + 4);
      check(n_ok == o0 + 1, "R6 tie test/low gives ok", n_ok - o0, 1);

      // R9: disabled with active inputs
      f0 = n_fast; o0 = n_ok; s0 = n_slow;
      @(negedge clk); en = 1'b0;
      half[0] = 10; half[1] = 60; half[2] = 4;
      run = 1'b1;
      settle(500);
      run = 1'b0;
      settle(4);
      check((n_fast + n_ok + n_slow) == (f0 + o0 + s0), "R9 disabled silent", n_fast + n_ok + n_slow - f0 - o0 - s0, 0);

      // free-running races
      free_run(10, 60, 4,   3000, 0, "R3 fast window");
      free_run(10, 60, 25,  3000, 1, "R4 ok window");
      free_run(10, 60, 150, 4000, 2, "R5 slow window");

      check(r7_viol == 0, "R7 exclusive single-cycle pulses", r7_viol, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule